// File: doc/BRIEF.md
# Card Supply Power Control Register

This block is a software-visible control register for a card slot. A simple peripheral write port in the bus clock domain sets a two-bit supply phase, a command-line open-drain select and a rod control bit. Software normally steps the slot supply from off, through a ramp phase in which the external supply is switched on and allowed to settle, into the steady on phase. The block does not enforce that order: any legal phase code written is taken as is.

Every accepted write is carried into the card clock domain by a toggle handshake. The card-side outputs are the supply enable pin, the open-drain select, the rod output and a card-bus output enable. The supply enable pin level is chosen by an external polarity input. While a transfer is in flight the register reports busy and drops any further write. The lockout lasts at least three card-clock periods plus two bus-clock periods.

Top module: `card_pwr_ctl`

## Requirements
- R1: After reset, rd_data is 0, busy is 0, cmd_open_drain and rod_out are 0, card_bus_oe is 1, and supply_en_pin is inactive (low when supply_pol is 1, high when supply_pol is 0).
- R2: A write whose bits 1:0 hold 00 (off), 10 (ramp) or 11 (on) sets the phase. The phase reads back in rd_data bits 1:0 and reaches the card-side outputs.
- R3: A write whose bits 1:0 hold 01 leaves the phase unchanged, while bits 6 and 7 of that write still take effect.
- R4: rd_data bits 5:2 and 31:8 read 0 whatever was written to them.
- R5: The supply is on in the ramp (10) and on (11) phases and off in phase 00. supply_en_pin equals the on state when supply_pol is 1 and its inverse when supply_pol is 0.
- R6: card_bus_oe is 0 in the ramp and on phases and 1 in the off phase.
- R7: Write bit 6 drives cmd_open_drain and write bit 7 drives rod_out. Both read back at the same positions.
- R8: busy is 1 in the bus cycle after an accepted write. It stays 1 for at least three rising card-clock edges and at least two rising bus-clock edges after the write edge.
- R9: A write presented while busy is 1 is dropped and changes neither rd_data nor any card-side output.
- R10: The card-side outputs keep their old values in the bus cycle after a write. They show the new value by the time busy falls.
- R11: Any legal phase may follow any other, for example off straight to on, or on straight to off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| prst_n | input | 1 | Bus-domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write value |
| rd_data | output | DATA_W | Register read value |
| busy | output | 1 | Write lockout active |
| mclk | input | 1 | Card clock |
| mrst_n | input | 1 | Card-domain asynchronous reset, active low |
| supply_pol | input | 1 | 1: supply enable pin active high; 0: active low |
| supply_en_pin | output | 1 | External supply enable |
| cmd_open_drain | output | 1 | Command-line open-drain select |
| rod_out | output | 1 | Rod control |
| card_bus_oe | output | 1 | Card-bus output enable |

## Verification
The bench writes the reserved phase code mixed with the control bits. A design that decoded 01 as a phase, or discarded the whole write, would show the wrong phase or stale control bits. It tries second writes in the cycle right after an accepted one. A design without a working lockout would take them and read back the later value. It counts card-clock and bus-clock edges across each lockout and samples the card outputs both just after the write and after busy falls. A design that released busy early, or passed data across before the handshake, would fail the edge counts or show the new value too soon. It also flips the polarity input and walks the phases out of order, which catches an inverted pin or a forced phase sequence.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
   typedef enum logic [1:0] {
      PH_OFF  = 2'b00,
      PH_RSVD = 2'b01,
      PH_RAMP = 2'b10,
      PH_ON   = 2'b11
   } phase_e;

   typedef struct packed {
      logic   rod;
      logic   od;
      phase_e phase;
   } ctl_s;

   localparam int CTL_W   = $bits(ctl_s);
   localparam int OD_BIT  = 6;
   localparam int ROD_BIT = 7;
   localparam int MIN_W   = ROD_BIT + 1;
endpackage

// File: rtl/cpc_sync.sv
module cpc_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cpc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cpc_bus_reg.sv
module cpc_bus_reg
   import cpc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              pclk,
   input  logic              prst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ack_tog_s,
   output logic              req_tog,
   output logic              busy,
   output ctl_s              ctl,
   output logic [DATA_W-1:0] rd_data
);
   if (DATA_W < MIN_W) begin : g_bad_width
      $error("cpc_bus_reg: DATA_W too small for the control fields");
   end

   logic     take;
   phase_e   wr_phase;

   assign busy     = req_tog ^ ack_tog_s;
   assign take     = wr_en && !busy;
   assign wr_phase = phase_e'(wr_data[1:0]);

   always_ff @(posedge pclk or negedge prst_n) begin
      if (!prst_n) begin
         req_tog <= 1'b0;
         ctl     <= '0;
      end else if (take) begin
         req_tog <= ~req_tog;
         ctl.od  <= wr_data[OD_BIT];
         ctl.rod <= wr_data[ROD_BIT];
         if (wr_phase != PH_RSVD) ctl.phase <= wr_phase;
      end
   end

   always_comb begin
      rd_data          = '0;
      rd_data[1:0]     = ctl.phase;
      rd_data[OD_BIT]  = ctl.od;
      rd_data[ROD_BIT] = ctl.rod;
   end

   // R8
   busy_after_write_chk: assert property (@(posedge pclk) disable iff (!prst_n)
      take |=> busy);

   // R9
   drop_while_busy_chk: assert property (@(posedge pclk) disable iff (!prst_n)
      (wr_en && busy) |=> $stable(ctl));

   // R3
   no_rsvd_phase_chk: assert property (@(posedge pclk) disable iff (!prst_n)
      ctl.phase != PH_RSVD);
endmodule

// File: rtl/cpc_card_side.sv
module cpc_card_side
   import cpc_pkg::*;
(
   input  logic mclk,
   input  logic mrst_n,
   input  logic req_tog_s,
   input  ctl_s ctl_in,
   input  logic supply_pol,
   output logic ack_tog,
   output logic supply_en_pin,
   output logic cmd_open_drain,
   output logic rod_out,
   output logic card_bus_oe
);
   ctl_s m_ctl;
   logic supply_on;

   always_ff @(posedge mclk or negedge mrst_n) begin
      if (!mrst_n) begin
         ack_tog <= 1'b0;
         m_ctl   <= '0;
      end else if (req_tog_s != ack_tog) begin
         ack_tog <= req_tog_s;
         m_ctl   <= ctl_in;
      end
   end

   assign supply_on      = (m_ctl.phase == PH_RAMP) || (m_ctl.phase == PH_ON);
   assign supply_en_pin  = supply_pol ? supply_on : ~supply_on;
   assign cmd_open_drain = m_ctl.od;
   assign rod_out        = m_ctl.rod;
   assign card_bus_oe    = (m_ctl.phase == PH_OFF);

   // R10
   hold_until_req_chk: assert property (@(posedge mclk) disable iff (!mrst_n)
      (req_tog_s == ack_tog) |=> $stable(m_ctl));
endmodule

// File: rtl/card_pwr_ctl.sv
module card_pwr_ctl
   import cpc_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              pclk,
   input  logic              prst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   input  logic              mclk,
   input  logic              mrst_n,
   input  logic              supply_pol,
   output logic              supply_en_pin,
   output logic              cmd_open_drain,
   output logic              rod_out,
   output logic              card_bus_oe
);
   logic req_tog, req_tog_s, ack_tog, ack_tog_s;
   ctl_s ctl;

   cpc_bus_reg #(.DATA_W(DATA_W)) u_bus (
      .pclk(pclk), .prst_n(prst_n), .wr_en(wr_en), .wr_data(wr_data),
      .ack_tog_s(ack_tog_s), .req_tog(req_tog), .busy(busy),
      .ctl(ctl), .rd_data(rd_data)
   );

   cpc_sync #(.STAGES(SYNC_STAGES), .W(1)) u_req_sync (
      .clk(mclk), .rst_n(mrst_n), .d(req_tog), .q(req_tog_s)
   );

   cpc_sync #(.STAGES(SYNC_STAGES), .W(1)) u_ack_sync (
      .clk(pclk), .rst_n(prst_n), .d(ack_tog), .q(ack_tog_s)
   );

   cpc_card_side u_card (
      .mclk(mclk), .mrst_n(mrst_n), .req_tog_s(req_tog_s), .ctl_in(ctl),
      .supply_pol(supply_pol), .ack_tog(ack_tog), .supply_en_pin(supply_en_pin),
      .cmd_open_drain(cmd_open_drain), .rod_out(rod_out), .card_bus_oe(card_bus_oe)
   );
endmodule

// File: tb/tb_card_pwr_ctl.sv
module tb_card_pwr_ctl;
   logic        pclk = 0, mclk = 0, prst_n = 0, mrst_n = 0;
   logic        wr_en = 0, supply_pol = 1;
   logic [31:0] wr_data = 0, rd_data;
   logic        busy, supply_en_pin, cmd_open_drain, rod_out, card_bus_oe;

   int checks = 0, failures = 0;
   int pcnt = 0, mcnt = 0;
   logic [1:0] e_ph = 0;
   logic       e_od = 0, e_rod = 0;

   always #2 pclk = ~pclk;
   always #5 mclk = ~mclk;
   always @(posedge pclk) pcnt++;
   always @(posedge mclk) mcnt++;

   card_pwr_ctl dut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd();
      return {24'b0, e_rod, e_od, 4'b0, e_ph};
   endfunction

   function automatic logic exp_pin(input logic [1:0] ph, input logic pol);
      return pol ? ph[1] : ~ph[1];
   endfunction

   task automatic check_card(input string req);
      chk(supply_en_pin == exp_pin(e_ph, supply_pol), req, "supply_en_pin",
          {31'b0, supply_en_pin}, {31'b0, exp_pin(e_ph, supply_pol)});
      chk(card_bus_oe == (e_ph == 2'b00), req, "card_bus_oe",
          {31'b0, card_bus_oe}, {31'b0, e_ph == 2'b00});
      chk(cmd_open_drain == e_od && rod_out == e_rod, req, "od/rod",
          {30'b0, rod_out, cmd_open_drain}, {30'b0, e_rod, e_od});
   endtask

   task automatic do_write(input logic [31:0] d, input bit try_busy,
                           input logic [31:0] d2, input string req);
      int p0, m0, to;
      @(negedge pclk);
      wr_en = 1; wr_data = d; p0 = pcnt; m0 = mcnt;
      @(negedge pclk);
      // R8: busy one cycle after accepted write
      chk(busy == 1'b1, "R8", "busy after write", {31'b0, busy}, 32'd1);
      // R10: card side still old
      check_card("R10");
      e_od = d[6]; e_rod = d[7];
      if (d[1:0] != 2'b01) e_ph = d[1:0];
      if (try_busy) begin
         wr_data = d2;
         @(negedge pclk);
      end
      wr_en = 0;
      to = 0;
      while (busy && to < 1000) begin @(negedge pclk); to++; end
      if (to >= 1000) chk(0, "R8", "watchdog busy stuck", 32'd1, 32'd0);
      chk((pcnt - p0) >= 3, "R8", "pclk edges in lockout", pcnt - p0, 32'd3);
      chk((mcnt - m0) >= 3, "R8", "mclk edges in lockout", mcnt - m0, 32'd3);
      chk(rd_data == exp_rd(), try_busy ? "R9" : req, "rd_data", rd_data, exp_rd());
      check_card(try_busy ? "R9" : req);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (4) @(negedge pclk);
      prst_n = 1; mrst_n = 1;
      repeat (2) @(negedge pclk);
      // R1
      chk(rd_data == 0, "R1", "rd_data", rd_data, 0);
      chk(busy == 0, "R1", "busy", {31'b0, busy}, 0);
      check_card("R1");
      supply_pol = 0; #1;
      chk(supply_en_pin == 1'b1, "R1", "pin low-active idle", {31'b0, supply_en_pin}, 1);
      supply_pol = 1;

      do_write(32'h0000_0002, 0, 0, "R2");       // ramp: R5 R6
      check_card("R5");
      do_write(32'h0000_0003, 0, 0, "R2");       // on
      check_card("R6");
      do_write(32'h0000_00C1, 0, 0, "R3");       // reserved code, bits 6/7 set
      chk(rd_data[1:0] == 2'b11, "R3", "phase kept", rd_data, 32'h3);
      do_write(32'hFFFF_FF7C, 0, 0, "R4");       // phase 00, od=1 rod=0
      chk(rd_data == 32'h0000_0040, "R4", "reserved bits zero", rd_data, 32'h40);
      do_write(32'h0000_0080, 0, 0, "R7");
      chk(rod_out == 1 && cmd_open_drain == 0, "R7", "rod only", {30'b0, rod_out, cmd_open_drain}, 32'h2);
      do_write(32'h0000_0003, 0, 0, "R11");      // off straight to on
      do_write(32'h0000_0000, 0, 0, "R11");      // on straight to off
      do_write(32'h0000_0002, 1, 32'h0000_00C3, "R9");
      supply_pol = 0; #1;
      check_card("R5");
      supply_pol = 1;

      for (int i = 0; i < 60; i++) begin
         logic [31:0] d;
         d = $urandom;
         if (i % 4 == 0) supply_pol = $urandom_range(0, 1);
         do_write(d, $urandom_range(0, 2) == 0, $urandom, "R2");
         chk(rd_data[5:2] == 0 && rd_data[31:8] == 0, "R4", "random reserved", rd_data, exp_rd());
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #400000;
      failures++; checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule